// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block drives the host side of a three-wire serial EEPROM link: chip select, serial clock, serial data toward the memory, and one serial data line back. A client hands it one command at a time on a valid/ready handshake, as a 2-bit opcode, an address and write data. The block frames the command, clocks it out on a divided serial clock and collects read data. After a command that programs or erases cells, it watches the busy line until the memory is ready, or until a cycle budget runs out.

The memory may be organised as 16-bit words with 6 address bits, or as bytes with 7 address bits. The client picks the organisation per command. Completion is a single-cycle `done` pulse. With it come `rdata` (for reads) and a `timeout` flag (for programming commands whose status poll never saw ready). A parameter adds one trailing clock with data-in high after ready is seen. This makes the memory release its data-out line, which lets the two data lines be wired together.

Top module: `ee3w_host`

## Requirements
- R1: A command is sent MSB first as a 1 start bit, then `req_op[1:0]`, then the address: `req_addr[5:0]` when `wide_org`=1, or `req_addr[6:0]` when `wide_org`=0. Commands that carry data then append `req_wdata[15:0]` (wide) or `req_wdata[7:0]` (byte). These are op 01, and op 00 with address top bits 01.
- R2: `ee_sk` pulses only while `ee_cs` is high. Its high and low phases each last HALF system clocks, and `ee_di` never changes while `ee_sk` is high.
- R3: For op 10 (read), the bit captured during the last address bit is a dummy and is discarded. The next 16 bits (wide) or 8 bits (byte) are assembled MSB first into `rdata`, zero-extended in byte mode, and are valid while `done` is high.
- R4: Programming commands are op 01, op 11, and op 00 with address top bits 01 or 10. The address top bits are `req_addr[5:4]` when wide and `req_addr[6:5]` when byte. After the frame of such a command, `ee_cs` goes low and then high again, and the block samples `ee_do`. Low means busy, high means ready, and ready ends the command with `timeout`=0.
- R5: If `ee_do` stays low for POLL_LIMIT clocks of polling, chip select drops and `done` pulses with `timeout`=1.
- R6: Non-programming commands complete with a single chip-select window and `timeout`=0. These are reads, and op 00 with address top bits 00 or 11.
- R7: With REL_DUMMY=1, exactly one serial clock pulse with `ee_di`=1 follows a successful poll, before chip select falls. No such pulse follows a timeout.
- R8: Every rise of `ee_cs`, including the first after reset, follows at least CS_GAP clocks with `ee_cs` low.
- R9: `req_ready` is high only while idle, and then chip select is low. A request presented while `req_ready` is low is ignored and produces no completion.
- R10: After reset, `ee_cs`, `ee_sk` and `done` are low and `req_ready` is high. `done` lasts exactly one cycle and occurs with `ee_cs` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | Command opcode |
| req_addr | input | 7 | Address; bits 5:0 used in wide mode |
| req_wdata | input | 16 | Write data; bits 7:0 used in byte mode |
| wide_org | input | 1 | 1 = 16-bit words, 0 = bytes |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Status poll expired (valid with done) |
| rdata | output | 16 | Read data (valid with done) |

## Verification
The assertions assume the request fields are driven and held stable by the client until acceptance. They also assume `ee_do` obeys the serial protocol: its value changes only after a rising serial clock, and it is sampled no earlier than the end of the high phase. HALF is at least 2 so that the memory model, which samples the serial clock on system clock edges, can update data-out within the high phase. The bench's memory model reacts only to serial clock edges and chip select transitions. Every command is issued through the handshake and waits for its completion. The one deliberate violation is a request held while `req_ready` is low, which is dropped before the block returns to idle.

// File: rtl/ee3w_host.sv
module ee3w_host #(
  parameter int HALF       = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 2000,
  parameter bit REL_DUMMY  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_op,
  input  logic [6:0]  req_addr,
  input  logic [15:0] req_wdata,
  input  logic        wide_org,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do,
  output logic        done,
  output logic        timeout,
  output logic [15:0] rdata
);
  localparam int MX = (POLL_LIMIT > CS_GAP) ? ((POLL_LIMIT > HALF) ? POLL_LIMIT : HALF)
                                            : ((CS_GAP > HALF) ? CS_GAP : HALF);
  localparam int CW = $clog2(MX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_SHIFT, S_POLL, S_REL, S_FIN} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [5:0]  bitn;
  logic [31:0] tx;
  logic [15:0] rx;
  logic        sk_q, poll_q, sent_q, org_q, to_q;

  wire [1:0] top      = wide_org ? req_addr[5:4] : req_addr[6:5];
  wire       op_bulk  = req_op == 2'b00;
  wire       wtype    = req_op == 2'b01 || req_op == 2'b11 || (op_bulk && (top == 2'b01 || top == 2'b10));
  wire       has_data = req_op == 2'b01 || req_op == 2'b10 || (op_bulk && top == 2'b01);
  wire [5:0] nbits    = (wide_org ? 6'd9 : 6'd10) + (has_data ? (wide_org ? 6'd16 : 6'd8) : 6'd0);
  wire [31:0] frame   = wide_org ? {1'b1, req_op, req_addr[5:0], req_wdata, 7'd0}
                                 : {1'b1, req_op, req_addr, req_wdata[7:0], 14'd0};
  wire       half_end = cnt == CW'(HALF - 1);

  assign req_ready = st == S_IDLE;
  assign ee_cs     = st == S_SHIFT || st == S_POLL || st == S_REL;
  assign ee_sk     = sk_q;
  assign ee_di     = (st == S_SHIFT && tx[31]) || st == S_REL;
  assign done      = st == S_FIN;
  assign timeout   = to_q;
  assign rdata     = org_q ? rx : {8'h00, rx[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      tx     <= '0;
      rx     <= '0;
      sk_q   <= 1'b0;
      poll_q <= 1'b0;
      sent_q <= 1'b0;
      org_q  <= 1'b1;
      to_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          tx     <= frame;
          bitn   <= nbits;
          poll_q <= wtype;
          sent_q <= 1'b0;
          org_q  <= wide_org;
          to_q   <= 1'b0;
          cnt    <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == CW'(CS_GAP - 1)) begin
            cnt <= '0;
            st  <= sent_q ? S_POLL : S_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        S_SHIFT, S_REL: begin
          if (half_end) begin
            cnt  <= '0;
            sk_q <= ~sk_q;
            if (sk_q) begin
              if (st == S_SHIFT) begin
                tx   <= tx << 1;
                rx   <= {rx[14:0], ee_do};
                bitn <= bitn - 1'b1;
                if (bitn == 6'd1) begin
                  sent_q <= 1'b1;
                  st     <= poll_q ? S_WAIT : S_FIN;
                end
              end else st <= S_FIN;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_POLL: begin
          if (ee_do) begin
            cnt <= '0;
            st  <= REL_DUMMY ? S_REL : S_FIN;
          end else if (cnt == CW'(POLL_LIMIT - 1)) begin
            to_q <= 1'b1;
            st   <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ee3w_host_chk.sv
module ee3w_host_chk #(
  parameter int HALF   = 2,
  parameter int CS_GAP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic done
);
  logic [15:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ee_cs ? 16'd0 : (lo_cnt == 16'hFFFF ? lo_cnt : lo_cnt + 16'd1);
      hi_cnt <= ee_sk ? hi_cnt + 16'd1 : 16'd0;
    end
  end

  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs); // R2
  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> $stable(ee_di)); // R2
  AST_SK_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(ee_sk) |-> hi_cnt == 16'(HALF)); // R2
  AST_CS_LOW_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ee_cs) |-> lo_cnt >= 16'(CS_GAP)); // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !ee_cs && !ee_sk); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_DONE_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) done |-> !ee_cs); // R10
endmodule

bind ee3w_host ee3w_host_chk #(.HALF(HALF), .CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ee_cs(ee_cs),
  .ee_sk(ee_sk), .ee_di(ee_di), .done(done)
);

// File: tb/sim_ee3w_host.sv
module sim_ee3w_host;
  localparam int HALF = 2, CS_GAP = 4, POLL_LIMIT = 2000, BUSY_T = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wide_org = 1'b1;
  logic [1:0] req_op = '0;
  logic [6:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, ee_cs, ee_sk, ee_di, ee_do, done, timeout;
  logic [15:0] rdata;

  always #5 clk = ~clk;

  ee3w_host #(.HALF(HALF), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT), .REL_DUMMY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .wide_org(wide_org),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .done(done), .timeout(timeout), .rdata(rdata)
  );

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem16 [64];
  logic [7:0]  mem8  [128];
  logic sk_d = 0, cs_d = 0, status = 0, dout = 0, stuck = 0;
  int busy = 0, dummies = 0, n = 0;
  bit started = 0, rd = 0, pend = 0;
  logic [31:0] sr = 0;
  logic [15:0] rdq = 0;
  logic [1:0] m_op = 0;
  logic [6:0] m_addr = 0;
  logic [1:0] m_top = 0;

  assign ee_do = status ? (busy == 0) : dout;

  always @(posedge clk) begin
    int aw, dw;
    aw = wide_org ? 6 : 7;
    dw = wide_org ? 16 : 8;
    sk_d <= ee_sk;
    cs_d <= ee_cs;
    if (busy > 0 && !stuck) busy <= busy - 1;
    if (cs_d && !ee_cs) begin
      started = 0; rd = 0; n = 0;
      if (pend) begin busy <= BUSY_T; status <= 1'b1; pend = 0; end
      else status <= 1'b0;
    end else if (ee_cs && ee_sk && !sk_d) begin
      if (status) begin
        if (ee_di) dummies++;
      end else if (!started) begin
        if (ee_di) begin started = 1; n = 0; sr = 0; end
      end else if (rd) begin
        dout <= rdq[dw-1];
        rdq = rdq << 1;
      end else begin
        sr = {sr[30:0], ee_di};
        n++;
        if (n == 2 + aw) begin
          m_op   = 2'((sr >> aw) & 32'd3);
          m_addr = 7'(sr & ((32'd1 << aw) - 1));
          m_top  = 2'(m_addr >> (aw - 2));
          if (m_op == 2'b10) begin
            rdq = wide_org ? mem16[m_addr[5:0]] : {8'h00, mem8[m_addr]};
            rd = 1;
            dout <= 1'b0;
          end else if (m_op == 2'b11) begin
            if (wide_org) mem16[m_addr[5:0]] = 16'hFFFF; else mem8[m_addr] = 8'hFF;
            pend = 1;
          end else if (m_op == 2'b00 && m_top == 2'b10) begin
            for (int i = 0; i < 64; i++) mem16[i] = 16'hFFFF;
            for (int i = 0; i < 128; i++) mem8[i] = 8'hFF;
            pend = 1;
          end
        end else if (n == 2 + aw + dw && (m_op == 2'b01 || (m_op == 2'b00 && m_top == 2'b01))) begin
          if (m_op == 2'b01) begin
            if (wide_org) mem16[m_addr[5:0]] = sr[15:0]; else mem8[m_addr] = sr[7:0];
          end else begin
            for (int i = 0; i < 64; i++) mem16[i] = sr[15:0];
            for (int i = 0; i < 128; i++) mem8[i] = sr[7:0];
          end
          pend = 1;
        end
      end
    end
  end

  // port timing monitors
  int rises = 0, lo_len = 0, hi_len = 0, bad_gap = 0, bad_half = 0;
  logic cs_p = 0;
  always @(posedge clk) begin
    cs_p <= ee_cs;
    if (!rst_n) lo_len = 0;
    else begin
      if (ee_cs && !cs_p) rises++;
      if (!ee_cs) lo_len++;
      else if (lo_len != 0) begin
        if (lo_len < CS_GAP) bad_gap++;
        lo_len = 0;
      end
      if (ee_sk) hi_len++;
      else if (hi_len != 0) begin
        if (hi_len != HALF) bad_half++;
        hi_len = 0;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [15:0] d; bit to; bit isrd; logic [1:0] op; logic [6:0] addr; int nrise; string tag;
  } exp_t;
  exp_t q[$];
  int rise_base = 0;
  bit done_p = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_p) check(!done, "R10 done one cycle", done, 0);
      done_p = done;
      if (done) begin
        if (q.size() == 0) check(0, "R9 completion without accepted request", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(timeout == e.to, e.tag, timeout, e.to);
          check(m_op == e.op && m_addr == e.addr, "R1 frame op/addr", {m_op, m_addr}, {e.op, e.addr});
          check(rises - rise_base == e.nrise, "R4/R6 chip-select windows", rises - rise_base, e.nrise);
          if (e.isrd) check(rdata == e.d, "R3 read data", rdata, e.d);
          rise_base = rises;
        end
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [6:0] addr, input logic [15:0] wd,
                     input bit isrd, input logic [15:0] expd, input bit to, input int nrise,
                     input int ndum, input string tag, input bit probe);
    exp_t e;
    int d0;
    e.d = expd; e.to = to; e.isrd = isrd; e.op = op; e.addr = addr; e.nrise = nrise; e.tag = tag;
    d0 = dummies;
    @(negedge clk);
    rise_base = rises;
    q.push_back(e);
    req_op = op; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (probe) begin
      repeat (3) @(negedge clk);
      check(!req_ready, "R9 ready low while busy", req_ready, 0);
      req_op = 2'b10; req_addr = 7'h01; req_valid = 1'b1;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(dummies - d0 == ndum, "R7 release pulses", dummies - d0, ndum);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem16[i] = 16'h0;
    for (int i = 0; i < 128; i++) mem8[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ee_cs && !ee_sk && !done && req_ready, "R10 reset state",
          {ee_cs, ee_sk, done, req_ready}, 4'b0001);

    wide_org = 1'b1;
    cmd(2'b00, 7'h30, 16'h0, 0, 0, 0, 1, 0, "R6 enable no poll", 0);
    cmd(2'b01, 7'h05, 16'hA5C3, 0, 0, 0, 2, 1, "R4 write polled", 0);
    cmd(2'b10, 7'h05, 16'h0, 1, 16'hA5C3, 0, 1, 0, "R3 read wide", 1);
    cmd(2'b01, 7'h3F, 16'h8001, 0, 0, 0, 2, 1, "R4 write top addr", 0);
    cmd(2'b10, 7'h3F, 16'h0, 1, 16'h8001, 0, 1, 0, "R3 read top addr", 0);
    cmd(2'b11, 7'h05, 16'h0, 0, 0, 0, 2, 1, "R4 erase polled", 0);
    cmd(2'b10, 7'h05, 16'h0, 1, 16'hFFFF, 0, 1, 0, "R3 read erased", 0);
    cmd(2'b00, 7'h10, 16'h1234, 0, 0, 0, 2, 1, "R4 bulk write", 0);
    cmd(2'b10, 7'h22, 16'h0, 1, 16'h1234, 0, 1, 0, "R3 read after bulk", 0);

    wide_org = 1'b0;
    cmd(2'b00, 7'h40, 16'h0, 0, 0, 0, 2, 1, "R4 bulk erase byte", 0);
    cmd(2'b10, 7'h7F, 16'h0, 1, 16'h00FF, 0, 1, 0, "R3 read byte erased", 0);
    cmd(2'b01, 7'h55, 16'hEE3C, 0, 0, 0, 2, 1, "R4 write byte", 0);
    cmd(2'b10, 7'h55, 16'h0, 1, 16'h003C, 0, 1, 0, "R3 read byte", 0);
    cmd(2'b01, 7'h7F, 16'h0081, 0, 0, 0, 2, 1, "R4 write byte top", 0);
    cmd(2'b10, 7'h7F, 16'h0, 1, 16'h0081, 0, 1, 0, "R3 read byte top", 0);

    stuck = 1'b1;
    cmd(2'b00, 7'h00, 16'h0, 0, 0, 0, 1, 0, "R6 disable no poll", 0);
    cmd(2'b01, 7'h01, 16'h0077, 0, 0, 1, 2, 0, "R5 poll timeout", 0);
    stuck = 1'b0;
    repeat (BUSY_T + 10) @(negedge clk);
    cmd(2'b10, 7'h01, 16'h0, 1, 16'h0077, 0, 1, 0, "R3 read after timeout", 0);

    check(bad_half == 0, "R2 serial clock high phase", bad_half, 0);
    check(bad_gap == 0, "R8 chip-select low gap", bad_gap, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule